// File: doc/BRIEF.md
# Synchronous host port slave interface

This block lets an external host master reach an internal word-addressed memory over a shared 32-bit synchronous bus. The host uses a register-select line to pick one of two targets. One target is the address register, which holds a word address. The other is the data window, which reads or writes the memory word that the address register points at. Every transfer to the data window moves the address register on by one word, so a burst of beats walks through consecutive words.

An access opens when the host pulls the active-low strobe low for one clock. The block latches the register select on that clock. It takes the direction from the read/write line and answers each beat with an active-low ready. Read data leaves on a separate output bus, together with an output enable for the shared pads. Each read beat is preceded by one wait cycle, in which the memory is fetched. The host marks the final beat with a burst-last line. A back-off input holds the access off the bus until it drops, and the access then resumes at the same word. The polarities of the burst-last line and of the read/write line are sampled from two configuration pins while reset is held.

The control state machine has five states:
- ST_IDLE: no access is open. A strobe moves it to ST_WBEAT when the direction is a write, and to ST_RWAIT when it is a read.
- ST_WBEAT: each cycle is a write beat. It returns to ST_IDLE on a beat marked last, and it stays in ST_WBEAT otherwise.
- ST_RWAIT: the memory fetch cycle. It always moves on to ST_RBEAT.
- ST_RBEAT: one read data beat. It goes to ST_IDLE on a beat marked last, and back to ST_RWAIT otherwise.
- ST_HOLD: entered from ST_WBEAT, ST_RWAIT or ST_RBEAT while back-off is high. When back-off drops it goes to ST_WBEAT for a write and to ST_RWAIT for a read.

Top module: `hps_slave`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) leaves bus_rdy_n at 1 and bus_doe at 0, and clears the address register, so a following read of the address register returns 0.
- R2: With bus_strobe_n held at 1 and no access open, bus_rdy_n stays at 1 and bus_doe stays at 0 whatever the other bus inputs do.
- R3: A write with bus_sel=1 loads the address register from bus_din[AW-1:0] and ignores the byte enables. A read with bus_sel=1 returns the address register zero-extended to 32 bits. Transfers to the address register do not change it otherwise.
- R4: A write with bus_sel=0 stores each beat, in a cycle with bus_rdy_n=0, at the word named by the address register. The address register then increments by one and wraps modulo 2^AW.
- R5: bus_be_n is active low. Bit i qualifies data bits 8i+7 down to 8i. Only the enabled bytes of the target word change.
- R6: Each read beat is preceded by exactly one cycle with bus_rdy_n=1. In the beat cycle bus_rdy_n=0, bus_doe=1 and bus_dout carries the word. bus_doe is 1 in no other cycle.
- R7: An access ends after the beat in which burst-last is active. It is active high when cfg_last_hi was 1 during reset and active low when it was 0. The cycle after the final beat has bus_rdy_n=1 and bus_doe=0.
- R8: bus_rw means write when it equals the value cfg_wr_hi had during reset, and read otherwise.
- R9: While bus_backoff is 1, bus_rdy_n=1 and bus_doe=0, and no beat completes: nothing is written and the address does not move. After back-off drops, the access resumes at the same word.
- R10: Each read beat to the data window also increments the address register by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration pins are sampled while it is low |
| cfg_last_hi | input | 1 | Burst-last polarity: 1 means active high |
| cfg_wr_hi | input | 1 | Value of bus_rw that means write |
| bus_strobe_n | input | 1 | Active-low strobe, low on the first clock of an access |
| bus_sel | input | 1 | Target: 0 is the data window, 1 is the address register |
| bus_rw | input | 1 | Direction, polarity set by cfg_wr_hi |
| bus_last | input | 1 | Burst-last marker, polarity set by cfg_last_hi |
| bus_be_n | input | 4 | Active-low byte enables |
| bus_backoff | input | 1 | Suspends the current access while high |
| bus_din | input | 32 | Data from the host |
| bus_dout | output | 32 | Read data to the host |
| bus_doe | output | 1 | Output enable for the shared data pads |
| bus_rdy_n | output | 1 | Active-low ready |
| mem_addr | output | AW | Word address to the memory |
| mem_rd | output | 1 | Memory read request; data is expected one clock later |
| mem_rdata | input | 32 | Read data from the memory |
| mem_wr | output | 1 | Memory write strobe |
| mem_wbe | output | 4 | Active-high byte write enables |
| mem_wdata | output | 32 | Memory write data |

## Verification
The bench builds the block with the default parameters, DW=32 and AW=8. With an 8-bit word address, the 256-word behavioural memory covers the whole address space. A load of 0xFF followed by one data beat then reaches the wrap of the address register back to 0. The bench resets the block a second time with both configuration pins flipped, which brings the other burst-last and read/write polarities within reach. It also suspends both a write beat and a read beat with back-off.

// File: rtl/hps_pkg.sv
package hps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBEAT,
        ST_RWAIT,
        ST_RBEAT,
        ST_HOLD
    } hps_state_e;
endpackage

// File: rtl/hps_ctrl.sv
module hps_ctrl
    import hps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_last_hi,
    input  logic       cfg_wr_hi,
    input  logic       strobe_n,
    input  logic       sel,
    input  logic       rw,
    input  logic       last_in,
    input  logic       backoff,
    output hps_state_e state,
    output logic       sel_q,
    output logic       wr_beat,
    output logic       rd_beat,
    output logic       fetch,
    output logic       rdy_n,
    output logic       doe
);
    hps_state_e nxt, resume_q, resume_nxt;
    logic       last_pol_q, wr_pol_q;
    logic       last_act, wr_req;

    assign last_act = last_pol_q ? last_in : ~last_in;
    assign wr_req   = wr_pol_q ? rw : ~rw;

    // configuration pins are sampled while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_pol_q <= cfg_last_hi;
            wr_pol_q   <= cfg_wr_hi;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            resume_q <= ST_RWAIT;
            sel_q    <= 1'b0;
        end else begin
            state    <= nxt;
            resume_q <= resume_nxt;
            if (state == ST_IDLE && !strobe_n) begin
                sel_q <= sel;
            end
        end
    end

    // next state
    always_comb begin
        nxt        = state;
        resume_nxt = resume_q;
        unique case (state)
            ST_IDLE: begin
                if (!strobe_n) begin
                    nxt = wr_req ? ST_WBEAT : ST_RWAIT;
                end
            end
            ST_WBEAT: begin
                if (backoff) begin
                    nxt        = ST_HOLD;
                    resume_nxt = ST_WBEAT;
                end else if (last_act) begin
                    nxt = ST_IDLE;
                end
            end
            ST_RWAIT: begin
                if (backoff) begin
                    nxt        = ST_HOLD;
                    resume_nxt = ST_RWAIT;
                end else begin
                    nxt = ST_RBEAT;
                end
            end
            ST_RBEAT: begin
                if (backoff) begin
                    nxt        = ST_HOLD;
                    resume_nxt = ST_RWAIT;
                end else if (last_act) begin
                    nxt = ST_IDLE;
                end else begin
                    nxt = ST_RWAIT;
                end
            end
            ST_HOLD: begin
                if (!backoff) begin
                    nxt = resume_q;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_beat = 1'b0;
        rd_beat = 1'b0;
        fetch   = 1'b0;
        unique case (state)
            ST_WBEAT: wr_beat = !backoff;
            ST_RBEAT: rd_beat = !backoff;
            ST_RWAIT: fetch   = 1'b1;
            default: begin
                wr_beat = 1'b0;
            end
        endcase
        rdy_n = !(wr_beat || rd_beat);
        doe   = rd_beat;
    end

    AST_DOE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        doe |-> !rdy_n); // R6
    AST_BEAT_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RBEAT) |-> ($past(state) == ST_RWAIT)); // R6
    AST_BACKOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        backoff |-> (rdy_n && !doe)); // R9
    AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (rdy_n && !doe)); // R2
endmodule

// File: rtl/hps_addr.sv
module hps_addr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (inc) begin
            addr <= addr + ONE;
        end
    end

    AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (addr == $past(load_val))); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> (addr == $past(addr) + ONE)); // R4
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(addr)); // R9
endmodule

// File: rtl/hps_dpath.sv
module hps_dpath #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic            sel_q,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   mem_rdata,
    input  logic [DW/8-1:0] be_n,
    input  logic [DW-1:0]   din,
    output logic [DW-1:0]   dout,
    output logic [DW/8-1:0] wbe,
    output logic [DW-1:0]   wdata
);
    localparam int NB = DW / 8;

    assign dout  = sel_q ? {{(DW-AW){1'b0}}, addr} : mem_rdata;
    assign wdata = din;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign wbe[i] = ~be_n[i];
    end
endmodule

// File: rtl/hps_slave.sv
module hps_slave
    import hps_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_last_hi,
    input  logic            cfg_wr_hi,
    input  logic            bus_strobe_n,
    input  logic            bus_sel,
    input  logic            bus_rw,
    input  logic            bus_last,
    input  logic [DW/8-1:0] bus_be_n,
    input  logic            bus_backoff,
    input  logic [DW-1:0]   bus_din,
    output logic [DW-1:0]   bus_dout,
    output logic            bus_doe,
    output logic            bus_rdy_n,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    input  logic [DW-1:0]   mem_rdata,
    output logic            mem_wr,
    output logic [DW/8-1:0] mem_wbe,
    output logic [DW-1:0]   mem_wdata
);
    hps_state_e    state;
    logic          sel_q, wr_beat, rd_beat, fetch;
    logic          addr_load, addr_inc;
    logic [AW-1:0] addr;

    hps_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_last_hi(cfg_last_hi),
        .cfg_wr_hi  (cfg_wr_hi),
        .strobe_n   (bus_strobe_n),
        .sel        (bus_sel),
        .rw         (bus_rw),
        .last_in    (bus_last),
        .backoff    (bus_backoff),
        .state      (state),
        .sel_q      (sel_q),
        .wr_beat    (wr_beat),
        .rd_beat    (rd_beat),
        .fetch      (fetch),
        .rdy_n      (bus_rdy_n),
        .doe        (bus_doe)
    );

    assign addr_load = wr_beat && sel_q;
    assign addr_inc  = (wr_beat || rd_beat) && !sel_q;

    hps_addr #(.AW(AW)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (addr_load),
        .load_val(bus_din[AW-1:0]),
        .inc     (addr_inc),
        .addr    (addr)
    );

    hps_dpath #(.DW(DW), .AW(AW)) u_dpath (
        .sel_q    (sel_q),
        .addr     (addr),
        .mem_rdata(mem_rdata),
        .be_n     (bus_be_n),
        .din      (bus_din),
        .dout     (bus_dout),
        .wbe      (mem_wbe),
        .wdata    (mem_wdata)
    );

    assign mem_addr = addr;
    assign mem_wr   = wr_beat && !sel_q;
    assign mem_rd   = fetch && !sel_q;

    AST_NO_WR_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !bus_doe); // R4
    AST_NO_WR_ON_BACKOFF: assert property (@(posedge clk) disable iff (!rst_n)
        bus_backoff |-> !mem_wr); // R9
    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R6
endmodule

// File: tb/hps_slave_bench.sv
module hps_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_l = 1'b0, cfg_w = 1'b1;
    logic        strobe_n = 1'b1, sel = 1'b0, rw = 1'b0, last = 1'b1, backoff = 1'b0;
    logic [3:0]  be_n = 4'h0;
    logic [31:0] din = '0, dout, rdata;
    logic        doe, rdy_n, mrd, mwr;
    logic [7:0]  maddr;
    logic [3:0]  wbe;
    logic [31:0] wdata;
    logic [31:0] mem [256];
    logic [31:0] rbuf [8];
    int          nchk = 0, nbad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    hps_slave u_hps_slave (
        .clk(clk), .rst_n(rst_n), .cfg_last_hi(cfg_l), .cfg_wr_hi(cfg_w),
        .bus_strobe_n(strobe_n), .bus_sel(sel), .bus_rw(rw), .bus_last(last),
        .bus_be_n(be_n), .bus_backoff(backoff), .bus_din(din), .bus_dout(dout),
        .bus_doe(doe), .bus_rdy_n(rdy_n), .mem_addr(maddr), .mem_rd(mrd),
        .mem_rdata(rdata), .mem_wr(mwr), .mem_wbe(wbe), .mem_wdata(wdata)
    );

    // behavioural memory, one-clock read latency
    initial for (int i = 0; i < 256; i++) mem[i] = '0;
    always @(posedge clk) begin
        if (mwr) begin
            for (int b = 0; b < 4; b++)
                if (wbe[b]) mem[maddr][8*b +: 8] <= wdata[8*b +: 8];
        end
        if (mrd) rdata <= mem[maddr];
    end

    function automatic logic lv_last(input bit act);
        return act ? cfg_l : ~cfg_l;
    endfunction
    function automatic logic lv_rw(input bit wr);
        return wr ? cfg_w : ~cfg_w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; strobe_n = 1'b1; backoff = 1'b0;
        last = lv_last(0); rw = lv_rw(0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_burst(input logic s, input logic [3:0] be, input logic [31:0] base, input int n);
        @(negedge clk);
        strobe_n = 1'b0; sel = s; rw = lv_rw(1); last = lv_last(0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            strobe_n = 1'b1; din = base + k; be_n = be; last = lv_last(k == n - 1);
            #1 chk(rdy_n == 1'b0, "R4 write beat ready", {31'd0, rdy_n}, 32'd0);
        end
        @(negedge clk);
        last = lv_last(0);
        #1 chk(rdy_n == 1'b1 && doe == 1'b0, "R7 write end", {31'd0, rdy_n}, 32'd1);
    endtask

    task automatic rd_burst(input logic s, input int n);
        @(negedge clk);
        strobe_n = 1'b0; sel = s; rw = lv_rw(0); last = lv_last(0);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            strobe_n = 1'b1; last = lv_last(0);
            #1 chk(rdy_n == 1'b1 && doe == 1'b0, "R6 wait cycle", {30'd0, doe, rdy_n}, 32'd1);
            @(negedge clk);
            last = lv_last(k == n - 1);
            #1 chk(rdy_n == 1'b0 && doe == 1'b1, "R6 read beat", {30'd0, doe, rdy_n}, 32'd2);
            rbuf[k] = dout;
        end
        @(negedge clk);
        last = lv_last(0);
        #1 chk(rdy_n == 1'b1 && doe == 1'b0, "R7 read end", {30'd0, doe, rdy_n}, 32'd1);
    endtask

    // {req, expected, data, be_n, sel, wr}
    localparam int NV = 17;
    localparam logic [73:0] VEC [NV] = '{
        {4'd3,  32'h0,        32'h00000010, 4'hF, 1'b1, 1'b1}, // R3 load
        {4'd4,  32'h0,        32'hA1B2C3D4, 4'h0, 1'b0, 1'b1}, // R4
        {4'd3,  32'h0,        32'h00000010, 4'h0, 1'b1, 1'b1},
        {4'd4,  32'hA1B2C3D4, 32'h0,        4'h0, 1'b0, 1'b0}, // R4 readback
        {4'd10, 32'h00000011, 32'h0,        4'h0, 1'b1, 1'b0}, // R10
        {4'd3,  32'h0,        32'h00000010, 4'h0, 1'b1, 1'b1},
        {4'd5,  32'h0,        32'hFFFFFF55, 4'hE, 1'b0, 1'b1}, // R5 byte 0
        {4'd3,  32'h0,        32'h00000010, 4'h0, 1'b1, 1'b1},
        {4'd5,  32'hA1B2C355, 32'h0,        4'h0, 1'b0, 1'b0}, // R5
        {4'd3,  32'h0,        32'h00000010, 4'h0, 1'b1, 1'b1},
        {4'd5,  32'h0,        32'h99FFFFFF, 4'h7, 1'b0, 1'b1}, // R5 byte 3
        {4'd3,  32'h0,        32'h00000010, 4'h0, 1'b1, 1'b1},
        {4'd5,  32'h99B2C355, 32'h0,        4'h0, 1'b0, 1'b0}, // R5
        {4'd3,  32'h0,        32'h000003FF, 4'h0, 1'b1, 1'b1}, // R3 AW bits
        {4'd3,  32'h000000FF, 32'h0,        4'h0, 1'b1, 1'b0}, // R3 zero-extend
        {4'd4,  32'h0,        32'hCAFEF00D, 4'h0, 1'b0, 1'b1},
        {4'd4,  32'h00000000, 32'h0,        4'h0, 1'b1, 1'b0}  // R4 wrap
    };

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++; nchk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        #1 chk(rdy_n == 1'b1 && doe == 1'b0, "R1 reset outputs", {30'd0, doe, rdy_n}, 32'd1);
        rd_burst(1'b1, 1);
        chk(rbuf[0] == 32'd0, "R1 address after reset", rbuf[0], 32'd0);

        // R2: no strobe, wiggle the other inputs
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            sel = c[0]; rw = c[1]; last = c[0]; be_n = 4'(c); din = 32'hDEAD0000 + c;
            #1 chk(rdy_n == 1'b1 && doe == 1'b0, "R2 no strobe", {30'd0, doe, rdy_n}, 32'd1);
        end
        last = lv_last(0);

        for (int v = 0; v < NV; v++) begin
            logic [73:0] e;
            e = VEC[v];
            if (e[0]) wr_burst(e[1], e[5:2], e[37:6], 1);
            else begin
                rd_burst(e[1], 1);
                chk(rbuf[0] == e[69:38], $sformatf("R%0d vector %0d", e[73:70], v), rbuf[0], e[69:38]);
            end
        end
        chk(mem[8'hFF] == 32'hCAFEF00D, "R4 top word", mem[8'hFF], 32'hCAFEF00D);

        // bursts, R4 R7 R10
        wr_burst(1'b1, 4'h0, 32'h20, 1);
        wr_burst(1'b0, 4'h0, 32'h1000, 4);
        rd_burst(1'b1, 1);
        chk(rbuf[0] == 32'h24, "R4 address after write burst", rbuf[0], 32'h24);
        wr_burst(1'b1, 4'h0, 32'h20, 1);
        rd_burst(1'b0, 4);
        for (int k = 0; k < 4; k++)
            chk(rbuf[k] == 32'h1000 + k, "R7 burst read word", rbuf[k], 32'h1000 + k);
        rd_burst(1'b1, 1);
        chk(rbuf[0] == 32'h24, "R10 address after read burst", rbuf[0], 32'h24);

        // R9 back-off on a write beat
        wr_burst(1'b1, 4'h0, 32'h40, 1);
        @(negedge clk);
        strobe_n = 1'b0; sel = 1'b0; rw = lv_rw(1);
        @(negedge clk);
        strobe_n = 1'b1; din = 32'h11111111; be_n = 4'h0; last = lv_last(1); backoff = 1'b1;
        #1 chk(rdy_n == 1'b1 && doe == 1'b0, "R9 write suspended", {30'd0, doe, rdy_n}, 32'd1);
        @(negedge clk);
        backoff = 1'b0;
        #1 chk(rdy_n == 1'b1, "R9 hold cycle", {31'd0, rdy_n}, 32'd1);
        @(negedge clk);
        din = 32'h22222222;
        #1 chk(rdy_n == 1'b0, "R9 write resumed", {31'd0, rdy_n}, 32'd0);
        @(negedge clk);
        last = lv_last(0);
        rd_burst(1'b1, 1);
        chk(rbuf[0] == 32'h41, "R9 one step only", rbuf[0], 32'h41);
        wr_burst(1'b1, 4'h0, 32'h40, 1);
        rd_burst(1'b0, 2);
        chk(rbuf[0] == 32'h22222222, "R9 resumed word", rbuf[0], 32'h22222222);
        chk(rbuf[1] == 32'h0, "R9 next word untouched", rbuf[1], 32'h0);

        // R9 back-off on a read beat
        wr_burst(1'b1, 4'h0, 32'h21, 1);
        @(negedge clk);
        strobe_n = 1'b0; sel = 1'b0; rw = lv_rw(0);
        @(negedge clk);
        strobe_n = 1'b1;
        @(negedge clk);
        backoff = 1'b1; last = lv_last(1);
        #1 chk(rdy_n == 1'b1 && doe == 1'b0, "R9 read suspended", {30'd0, doe, rdy_n}, 32'd1);
        @(negedge clk);
        backoff = 1'b0; last = lv_last(0);
        @(negedge clk);
        #1 chk(rdy_n == 1'b1 && doe == 1'b0, "R9 refetch wait", {30'd0, doe, rdy_n}, 32'd1);
        @(negedge clk);
        last = lv_last(1);
        #1 chk(doe == 1'b1 && dout == 32'h1001, "R9 read resumed", dout, 32'h1001);
        @(negedge clk);
        last = lv_last(0);
        rd_burst(1'b1, 1);
        chk(rbuf[0] == 32'h22, "R9 read step once", rbuf[0], 32'h22);

        // R1 reset mid-run, R7 R8 flipped polarities
        cfg_l = 1'b1; cfg_w = 1'b0;
        do_reset();
        rd_burst(1'b1, 1);
        chk(rbuf[0] == 32'd0, "R1 address cleared", rbuf[0], 32'd0);
        wr_burst(1'b1, 4'h0, 32'h30, 1);
        wr_burst(1'b0, 4'h0, 32'h5A5A0000, 2);
        rd_burst(1'b1, 1);
        chk(rbuf[0] == 32'h32, "R7 high-active last burst", rbuf[0], 32'h32);
        wr_burst(1'b1, 4'h0, 32'h30, 1);
        rd_burst(1'b0, 2);
        chk(rbuf[0] == 32'h5A5A0000, "R8 low means write", rbuf[0], 32'h5A5A0000);
        chk(rbuf[1] == 32'h5A5A0001, "R8 second word", rbuf[1], 32'h5A5A0001);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule